// File: doc/BRIEF.md
# Dual-Mode PCM Transmit Serial Port

This block serialises one 8-bit companded sample per time slot onto a time-division PCM highway. The sample arrives as a ready-made parallel word. The block drives it out most significant bit first, and the sign bit is that first bit. Two timing schemes are supported, chosen by a strap. In the fixed-rate scheme, the master clock is also the bit clock, and a frame-sync pulse marks the slot. An active-low slot strobe then tells a downstream buffer when the highway is driven. In the variable-rate scheme, a separate data clock shifts the bits, and a level-sensitive slot enable frames the transmission. While the enable stays high, the held word is sent again in every following slot.

All clock-like inputs (master clock, data clock, frame sync or enable) are oversampled by a faster system clock `clk`. Outputs therefore respond two `clk` cycles after the input edge that causes them. The serial line is modelled as a data bit plus a drive enable. The strobe is open-drain style: a 1 means released.

The outputs stay released after reset until four frame periods of master clock have passed. A counter on `clk` releases them as well whenever the master clock stops.

Top module: `pcm_tx_port`

## Requirements
- R1: With `fixed_mode`=1, the slot starts at the first master-clock rising edge at which `fsync` is seen high, after it was seen low at the previous rising edge. That edge and the next seven rising edges drive `sample_in` bits 7 down to 0 onto `pcm_out`. Each bit appears two `clk` cycles after its edge, and `pcm_out` changes at no other time.
- R2: In fixed-rate mode, `slot_n` goes low and `pcm_oe` goes high together with the first bit. Both stay so until the master-clock falling edge that follows the eighth bit. After that edge, `pcm_oe` returns to 0 and `slot_n` returns to 1. `slot_n` is never low while `pcm_oe` is 0.
- R3: The word is taken from `sample_in` only at a slot or frame start. A change of `sample_in` afterwards is not sent in the current slot. In variable-rate mode, it is also not sent in any repeated slot of the same frame.
- R4: With `fixed_mode`=0, a rising `fsync` (the enable) captures the word, sets `pcm_oe`=1 and presents bit 7. Each `dclk` rising edge while the enable is high drives the next bit, MSB first. After bit 0, the sequence wraps to bit 7, so the same word repeats in every later slot.
- R5: In variable-rate mode, `pcm_oe` drops to 0 within two `clk` cycles after the enable goes low, and `dclk` then has no effect on it. `slot_n` stays 1 throughout variable-rate mode.
- R6: The strap `fixed_mode` selects the scheme: 1 gives fixed rate and 0 gives variable rate. In fixed-rate mode, an `fsync` held high over many master-clock cycles yields exactly one 8-bit slot with no repetition.
- R7: `ratio_sel` gives the master-clock cycles per frame N: 00 gives 256, 01 gives 193, 10 gives 192 and 11 gives 256. After reset, no slot is served before master-clock rising edge 4·N+1. A slot whose first bit falls on edge 4·N is ignored, and `pcm_oe` stays 0.
- R8: If no master-clock edge occurs for `LOSS_LIMIT` `clk` cycles (default 2000, which is 20 µs at 100 MHz), the block aborts any slot. It then sets `pcm_oe`=0 and `slot_n`=1. When the master clock resumes, the next frame is served normally.
- R9: While `rst_n` is low, `pcm_oe`=0 and `slot_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Master clock (bit clock in fixed-rate mode) |
| dclk | input | 1 | Data clock for variable-rate mode |
| fsync | input | 1 | Frame sync (fixed rate) or slot enable (variable rate) |
| fixed_mode | input | 1 | Strap: 1 fixed rate, 0 variable rate |
| ratio_sel | input | 2 | Master-clock cycles per frame: 00/11 256, 01 193, 10 192 |
| sample_in | input | 8 | Companded sample word, bit 7 is the sign |
| pcm_out | output | 1 | Serial data bit |
| pcm_oe | output | 1 | Drive enable of the serial line (0 = high impedance) |
| slot_n | output | 1 | Active-low slot strobe, 1 = released |

## Verification
A wrong bit index or capture point appears at once as a wrong `pcm_out` value, sampled in the same master or data clock phase that should carry that bit. An off-by-one in the bit counter shows within one slot in two ways. The strobe may release a master-clock cycle early or late. In variable mode, the word may stop repeating with a shifted phase in its second slot. Errors in the power-up hold appear as an enabled line at edge 4·N or a silent line at 4·N+1. Errors in clock-loss detection show as a strobe still asserted, or released too early, around the `LOSS_LIMIT` window.

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int HOLD_FRAMES = 4,
  parameter int LOSS_LIMIT  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk,
  input  logic       dclk,
  input  logic       fsync,
  input  logic       fixed_mode,
  input  logic [1:0] ratio_sel,
  input  logic [7:0] sample_in,
  output logic       pcm_out,
  output logic       pcm_oe,
  output logic       slot_n
);

  localparam int HOLD_MAX = HOLD_FRAMES * 256;
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam int LW = $clog2(LOSS_LIMIT + 1);

  logic m1, m2, d1, d2, fs1, fs2, fs_last;
  logic mrise, mfall, drise, fs_rise;
  logic [HW-1:0] pu_cnt, hold_lim;
  logic [LW-1:0] loss_cnt;
  logic lost, ready, active;
  logic [2:0] bcnt;
  logic [7:0] word_q;

  assign mrise   = m1 & ~m2;
  assign mfall   = ~m1 & m2;
  assign drise   = d1 & ~d2;
  assign fs_rise = fs1 & ~fs2;
  assign ready   = (pu_cnt >= hold_lim) & ~lost;

  always_comb begin
    case (ratio_sel)
      2'b01:   hold_lim = HW'(HOLD_FRAMES * 193);
      2'b10:   hold_lim = HW'(HOLD_FRAMES * 192);
      default: hold_lim = HW'(HOLD_MAX);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m1, m2, d1, d2, fs1, fs2, fs_last} <= '0;
    end else begin
      m1 <= mclk;  m2 <= m1;
      d1 <= dclk;  d2 <= d1;
      fs1 <= fsync; fs2 <= fs1;
      if (mrise) fs_last <= fs1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_cnt   <= '0;
      loss_cnt <= '0;
      lost     <= 1'b0;
    end else begin
      if (mrise && pu_cnt < hold_lim) pu_cnt <= pu_cnt + HW'(1);
      if (m1 ^ m2) begin
        loss_cnt <= '0;
        lost     <= 1'b0;
      end else if (loss_cnt == LW'(LOSS_LIMIT)) begin
        lost <= 1'b1;
      end else begin
        loss_cnt <= loss_cnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_out <= 1'b0;
      pcm_oe  <= 1'b0;
      slot_n  <= 1'b1;
      active  <= 1'b0;
      bcnt    <= '0;
      word_q  <= '0;
    end else if (!ready) begin
      pcm_oe <= 1'b0;
      slot_n <= 1'b1;
      active <= 1'b0;
    end else if (fixed_mode) begin
      if (mrise) begin
        if (fs1 && !fs_last) begin
          word_q  <= sample_in;
          pcm_out <= sample_in[7];
          pcm_oe  <= 1'b1;
          slot_n  <= 1'b0;
          active  <= 1'b1;
          bcnt    <= 3'd1;
        end else if (active && bcnt != 3'd0) begin
          pcm_out <= word_q[~bcnt];
          bcnt    <= bcnt + 3'd1;
        end
      end else if (mfall && active && bcnt == 3'd0) begin
        active <= 1'b0;
        pcm_oe <= 1'b0;
        slot_n <= 1'b1;
      end
    end else begin
      slot_n <= 1'b1;
      active <= 1'b0;
      if (!fs1) begin
        pcm_oe <= 1'b0;
      end else if (fs_rise) begin
        word_q  <= sample_in;
        pcm_out <= sample_in[7];
        pcm_oe  <= 1'b1;
        bcnt    <= 3'd0;
      end else if (drise && pcm_oe) begin
        pcm_out <= word_q[~bcnt];
        bcnt    <= bcnt + 3'd1;
      end
    end
  end

  AST_DATA_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrise || drise || fs_rise) |=> $stable(pcm_out)); // R1
  AST_STROBE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_n |-> pcm_oe); // R2
  AST_VAR_ENABLE_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed_mode && !fs1) |=> !pcm_oe); // R5
  AST_VAR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !fixed_mode |=> slot_n); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_cnt < hold_lim) |=> (!pcm_oe && slot_n)); // R7
  AST_LOSS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (!pcm_oe && slot_n)); // R8

endmodule

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb_top;
  logic clk = 1'b0;
  logic rst_n, mclk, dclk, fsync, fixed_mode;
  logic [1:0] ratio_sel;
  logic [7:0] sample_in;
  logic pcm_out, pcm_oe, slot_n;

  int checks = 0, fails = 0, mcount = 0, mph = 7, dph = 5;
  bit mrun = 1'b0, drun = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pcm_tx_port dut_i (
    .clk(clk), .rst_n(rst_n), .mclk(mclk), .dclk(dclk), .fsync(fsync),
    .fixed_mode(fixed_mode), .ratio_sel(ratio_sel), .sample_in(sample_in),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .slot_n(slot_n));

  function automatic int frame_len(input logic [1:0] r);
    return (r == 2'b01) ? 193 : (r == 2'b10) ? 192 : 256;
  endfunction

  function automatic int exp_bit(input logic [7:0] w, input int b);
    return int'(w[7-b]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic nm;
    @(negedge clk);
    mph = (mph + 1) % 8;
    dph = (dph + 1) % 6;
    if (mrun) begin
      nm = (mph < 4);
      if (nm && !mclk && rst_n) mcount++;
      mclk = nm;
    end
    if (drun) dclk = (dph < 3);
  endtask

  task automatic to_mph(input int p);
    step();
    while (mph != p) step();
  endtask

  task automatic to_dph(input int p);
    step();
    while (dph != p) step();
  endtask

  task automatic reset_dut(input logic [1:0] r, input logic fm);
    rst_n = 1'b0; mclk = 1'b0; dclk = 1'b0; fsync = 1'b0;
    ratio_sel = r; fixed_mode = fm; sample_in = 8'h00;
    mrun = 1'b0; mph = 7; dph = 5; mcount = 0;
    repeat (3) @(negedge clk);
    check("R9 oe in reset", pcm_oe, 0);
    check("R9 strobe in reset", slot_n, 1);
    rst_n = 1'b1; mrun = 1'b1; drun = 1'b1;
  endtask

  task automatic bring_up(input logic [1:0] r, input logic fm);
    reset_dut(r, fm);
    while (mcount < 4 * frame_len(r) + 2) step();
  endtask

  task automatic send_fixed(input logic [7:0] w);
    if (mph != 1) to_mph(1);
    sample_in = w; fsync = 1'b1;
    to_mph(1);
    fsync = 1'b0;
    for (int b = 0; b < 8; b++) begin
      to_mph(3);
      if (b == 3) sample_in = ~w;
      check(b > 3 ? "R3 held word" : "R1 fixed bit", pcm_out, exp_bit(w, b));
      check("R2 oe in slot", pcm_oe, 1);
      if (b == 0 || b == 7) check("R2 strobe low", slot_n, 0);
      if (b < 7) begin
        to_mph(7);
        check("R2 oe between bits", pcm_oe, 1);
      end
    end
    to_mph(7);
    check("R2 oe after bit 8", pcm_oe, 0);
    check("R2 strobe released", slot_n, 1);
  endtask

  task automatic hold_edge(input logic [1:0] r);
    int lim;
    lim = 4 * frame_len(r);
    reset_dut(r, 1'b1);
    while (!(mcount == lim - 1 && mph == 1)) step();
    sample_in = 8'h5A; fsync = 1'b1;
    to_mph(1);
    fsync = 1'b0;
    for (int b = 0; b < 8; b++) begin
      to_mph(3);
      check("R7 quiet at edge 4N", pcm_oe, 0);
      check("R7 strobe at edge 4N", slot_n, 1);
    end
    reset_dut(r, 1'b1);
    while (!(mcount == lim && mph == 1)) step();
    send_fixed(8'hB6);
  endtask

  task automatic send_var(input logic [7:0] w, input int nslots);
    to_dph(3);
    sample_in = w; fsync = 1'b1;
    step(); step();
    check("R4 enable drives", pcm_oe, 1);
    check("R4 msb presented", pcm_out, exp_bit(w, 0));
    for (int s = 0; s < nslots; s++) begin
      for (int b = 0; b < 8; b++) begin
        to_dph(2);
        if (s == 0 && b == 1) sample_in = ~w;
        check(s > 0 ? "R4 repeat slot" : "R4 var bit", pcm_out, exp_bit(w, b));
        if (s > 0 && b == 0) check("R3 var repeat uses held word", pcm_out, exp_bit(w, 0));
        check("R4 oe in slot", pcm_oe, 1);
        check("R5 no strobe in var", slot_n, 1);
      end
    end
    to_dph(4);
    fsync = 1'b0;
    step(); step();
    check("R5 enable low off", pcm_oe, 0);
    repeat (12) step();
    check("R5 dclk ignored", pcm_oe, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    int on_cnt;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    hold_edge(2'b01);
    hold_edge(2'b10);

    bring_up(2'b00, 1'b1);
    send_fixed(8'h80);
    send_fixed(8'h01);
    send_fixed(8'hFF);
    send_fixed(8'h00);
    for (int i = 0; i < 30; i++) send_fixed(8'($urandom));

    to_mph(1);
    sample_in = 8'hE7; fsync = 1'b1;
    on_cnt = 0;
    for (int c = 0; c < 20; c++) begin
      to_mph(3);
      if (pcm_oe) on_cnt++;
    end
    fsync = 1'b0;
    check("R6 one slot per held sync", on_cnt, 8);

    to_mph(1);
    sample_in = 8'h3C; fsync = 1'b1;
    to_mph(1);
    fsync = 1'b0;
    to_mph(3);
    check("R8 slot running", pcm_oe, 1);
    mrun = 1'b0;
    repeat (1900) step();
    check("R8 still driving before limit", pcm_oe, 1);
    repeat (300) step();
    check("R8 released after loss", pcm_oe, 0);
    check("R8 strobe released after loss", slot_n, 1);
    mrun = 1'b1;
    repeat (40) step();
    send_fixed(8'h96);

    bring_up(2'b00, 1'b0);
    send_var(8'hC3, 3);
    for (int i = 0; i < 10; i++) send_var(8'($urandom), 1 + int'($urandom % 3));

    done = 1'b1;
    summary();
  end
endmodule